// File: doc/BRIEF.md
# Logical Device Configuration and I/O Conflict Test

This block holds the configuration registers of one logical device on an expansion card and decides whether the device answers reads on the I/O bus. Software reaches the registers through an index and a data byte: it places a register index on `cfg_idx`, and then either writes `cfg_wdata` with `cfg_wr` or reads `cfg_rdata`, which follows the index in the same cycle. The registers are an activate flag, a range-check control, eight I/O base addresses, two interrupt entries and two DMA channel entries.

The block compares each bus I/O read against the programmed base addresses. A read inside a window hits, and an active device signals a hit to its function logic on `fn_sel`. An inactive device can also run a conflict test. When range check is on, the device answers hits in its window with a fixed byte, 0x55 or 0xAA, so that software can find address clashes before it turns the device on.

Top module: `ldev_cfg_top`

## Requirements
- R1: Index 0x30 is the activate register. Bit 0 stores the active flag, and bits 7:1 read as 0.
- R2: Index 0x31 is the range-check control. Bit 1 enables the check and bit 0 selects the test byte. Bits 7:2 read as 0.
- R3: A write of 1 to the active flag is ignored while range check is enabled, so the flag keeps its value. Range check can be enabled while the device is active, and the device stays active.
- R4: For range i (0..7), index 0x60+2i holds base address bits 15:8 and index 0x61+2i holds bits 7:0. All 8 bits of each byte are read/write.
- R5: For entry i (0..1), index 0x70+2i holds the interrupt level in bits 3:0, with bits 7:4 reading 0. Index 0x71+2i holds the polarity in bit 1 (1 = high) and the trigger in bit 0 (1 = level), with bits 7:2 reading 0.
- R6: For entry i (0..1), index 0x74+i holds the DMA channel in bits 2:0, with bits 7:3 reading 0. The value 4 means no channel.
- R7: Either of two resets returns every register to 0, except that each DMA entry returns to 4: `rst_n` held low, or `cfg_rst` high for one clock. A `cfg_rst` pulse takes priority over a write in the same cycle.
- R8: A read with `io_rd` high hits range i when base_i is nonzero and base_i <= `io_addr` < base_i + IO_SPAN (default 8), with no wrap past 0xFFFF. A base of 0 disables its range. When `io_rd` is low or no range hits, `io_oe` is 0.
- R9: On a hit while the device is active, `io_oe`=1, `fn_sel`=1 and `io_data`=0x00.
- R10: On a hit while the device is inactive and range check is enabled, `io_oe`=1, `fn_sel`=0, and `io_data` is 0x55 when the select bit is 1 or 0xAA when it is 0.
- R11: No test byte is driven when range check is off or when the device is active. An inactive device with range check off leaves `io_oe` at 0 on a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rst | input | 1 | Synchronous pulse that restores power-up register values |
| cfg_idx | input | 8 | Register index |
| cfg_wr | input | 1 | Write strobe for the indexed register |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Contents of the indexed register |
| io_rd | input | 1 | Bus I/O read strobe |
| io_addr | input | 16 | Bus I/O address |
| io_oe | output | 1 | Device answers this read |
| io_data | output | 8 | Reply byte: the test pattern, or 0 |
| fn_sel | output | 1 | Read hits a window of the active device |

## Verification
Bus reads are tried in every combination of active flag and range-check state: inactive with the check off, inactive with the check on under both select values, active with the check off, and active after the check has been turned on. The results tell test-pattern replies apart from normal function selects and from silence. Addresses are placed on both edges of a window: the base, the last byte, one below the base and one past the end. A window near 0xFFFF checks that addresses do not wrap, and a zero base checks that an unprogrammed range stays disabled. Register writes use values with every bit set, which exposes any reserved bit that is stored. A write to the active flag under range check, and a reset pulse after programming, show that the blocked write is ignored and that the DMA entries restore to 4 rather than 0.

// File: rtl/ldev_cfg_pkg.sv
package ldev_cfg_pkg;
  localparam logic [7:0] IDX_ACT = 8'h30;
  localparam logic [7:0] IDX_CHK = 8'h31;
  localparam logic [7:0] IDX_IOB = 8'h60;
  localparam logic [7:0] IDX_IRQ = 8'h70;
  localparam logic [7:0] IDX_DMA = 8'h74;
  localparam logic [2:0] DMA_NONE = 3'd4;
  localparam logic [7:0] PAT_SET = 8'h55;
  localparam logic [7:0] PAT_CLR = 8'hAA;

  // True when addr lies in [base, base+span), computed in 17 bits so no wrap
  function automatic logic in_window(input logic [15:0] addr, input logic [15:0] base,
                                     input int unsigned span);
    logic [16:0] lo, hi, a;
    lo = {1'b0, base};
    hi = lo + 17'(span);
    a  = {1'b0, addr};
    return (base != 16'h0) && (a >= lo) && (a < hi);
  endfunction

  function automatic logic [7:0] test_byte(input logic sel);
    return sel ? PAT_SET : PAT_CLR;
  endfunction
endpackage

// File: rtl/ldev_regfile.sv
module ldev_regfile
  import ldev_cfg_pkg::*;
#(
  parameter int NUM_IO  = 8,
  parameter int NUM_IRQ = 2,
  parameter int NUM_DMA = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_rst,
  input  logic [7:0]                   cfg_idx,
  input  logic                         cfg_wr,
  input  logic [7:0]                   cfg_wdata,
  output logic [7:0]                   cfg_rdata,
  output logic                         act_o,
  output logic                         chk_en_o,
  output logic                         chk_sel_o,
  output logic [NUM_IO-1:0][15:0]      io_base_o
);
  logic                     act_q, chk_en_q, chk_sel_q;
  logic [NUM_IO-1:0][15:0]  io_base_q;
  logic [NUM_IRQ-1:0][3:0]  irq_lvl_q;
  logic [NUM_IRQ-1:0][1:0]  irq_typ_q;
  logic [NUM_DMA-1:0][2:0]  dma_q;

  // Named events for the checks
  logic wr_act, wr_act_blocked;
  assign wr_act         = cfg_wr && !cfg_rst && (cfg_idx == IDX_ACT);
  assign wr_act_blocked = wr_act && cfg_wdata[0] && chk_en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || cfg_rst) begin
      act_q     <= 1'b0;
      chk_en_q  <= 1'b0;
      chk_sel_q <= 1'b0;
      io_base_q <= '0;
      irq_lvl_q <= '0;
      irq_typ_q <= '0;
      for (int d = 0; d < NUM_DMA; d++) dma_q[d] <= DMA_NONE;
    end else if (cfg_wr) begin
      if (cfg_idx == IDX_ACT && !wr_act_blocked) act_q <= cfg_wdata[0];
      if (cfg_idx == IDX_CHK) begin
        chk_en_q  <= cfg_wdata[1];
        chk_sel_q <= cfg_wdata[0];
      end
      for (int i = 0; i < NUM_IO; i++) begin
        if (cfg_idx == 8'(IDX_IOB + 2*i))     io_base_q[i][15:8] <= cfg_wdata;
        if (cfg_idx == 8'(IDX_IOB + 2*i + 1)) io_base_q[i][7:0]  <= cfg_wdata;
      end
      for (int j = 0; j < NUM_IRQ; j++) begin
        if (cfg_idx == 8'(IDX_IRQ + 2*j))     irq_lvl_q[j] <= cfg_wdata[3:0];
        if (cfg_idx == 8'(IDX_IRQ + 2*j + 1)) irq_typ_q[j] <= cfg_wdata[1:0];
      end
      for (int d = 0; d < NUM_DMA; d++)
        if (cfg_idx == 8'(IDX_DMA + d)) dma_q[d] <= cfg_wdata[2:0];
    end
  end

  always_comb begin
    cfg_rdata = 8'h00;
    if (cfg_idx == IDX_ACT) cfg_rdata = {7'b0, act_q};
    if (cfg_idx == IDX_CHK) cfg_rdata = {6'b0, chk_en_q, chk_sel_q};
    for (int i = 0; i < NUM_IO; i++) begin
      if (cfg_idx == 8'(IDX_IOB + 2*i))     cfg_rdata = io_base_q[i][15:8];
      if (cfg_idx == 8'(IDX_IOB + 2*i + 1)) cfg_rdata = io_base_q[i][7:0];
    end
    for (int j = 0; j < NUM_IRQ; j++) begin
      if (cfg_idx == 8'(IDX_IRQ + 2*j))     cfg_rdata = {4'b0, irq_lvl_q[j]};
      if (cfg_idx == 8'(IDX_IRQ + 2*j + 1)) cfg_rdata = {6'b0, irq_typ_q[j]};
    end
    for (int d = 0; d < NUM_DMA; d++)
      if (cfg_idx == 8'(IDX_DMA + d)) cfg_rdata = {5'b0, dma_q[d]};
  end

  assign act_o     = act_q;
  assign chk_en_o  = chk_en_q;
  assign chk_sel_o = chk_sel_q;
  assign io_base_o = io_base_q;

  AST_ACT_RISE_NOCHK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_q) |-> !$past(chk_en_q)); // R3
  AST_ACT_BLOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_act_blocked |=> $stable(act_q)); // R3
  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rst |=> (!act_q && !chk_en_q && dma_q[0] == DMA_NONE)); // R7
  AST_ACT_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_idx == IDX_ACT) |-> (cfg_rdata[7:1] == 7'b0)); // R1
  AST_CHK_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_idx == IDX_CHK) |-> (cfg_rdata[7:2] == 6'b0)); // R2
endmodule

// File: rtl/ldev_io_decode.sv
module ldev_io_decode
  import ldev_cfg_pkg::*;
#(
  parameter int NUM_IO  = 8,
  parameter int IO_SPAN = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    io_rd,
  input  logic [15:0]             io_addr,
  input  logic [NUM_IO-1:0][15:0] io_base,
  input  logic                    act,
  input  logic                    chk_en,
  input  logic                    chk_sel,
  output logic                    io_oe,
  output logic [7:0]              io_data,
  output logic                    fn_sel
);
  logic [NUM_IO-1:0] hit_vec;
  logic any_hit, test_mode, pat_drive;

  for (genvar g = 0; g < NUM_IO; g++) begin : g_win
    assign hit_vec[g] = in_window(io_addr, io_base[g], IO_SPAN);
  end

  assign any_hit   = io_rd && (|hit_vec);
  assign test_mode = chk_en && !act;
  assign fn_sel    = any_hit && act;
  assign pat_drive = any_hit && test_mode;
  assign io_oe     = fn_sel || pat_drive;
  assign io_data   = pat_drive ? test_byte(chk_sel) : 8'h00;

  AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |-> !io_oe); // R8
  AST_FN_NO_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    fn_sel |-> (io_oe && io_data == 8'h00)); // R9
  AST_PATTERN_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe && !fn_sel) |-> (io_data == PAT_SET || io_data == PAT_CLR)); // R10
  AST_NO_PAT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_en |-> (io_data == 8'h00)); // R11
endmodule

// File: rtl/ldev_cfg_top.sv
module ldev_cfg_top
  import ldev_cfg_pkg::*;
#(
  parameter int NUM_IO  = 8,
  parameter int NUM_IRQ = 2,
  parameter int NUM_DMA = 2,
  parameter int IO_SPAN = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_rst,
  input  logic [7:0]  cfg_idx,
  input  logic        cfg_wr,
  input  logic [7:0]  cfg_wdata,
  output logic [7:0]  cfg_rdata,
  input  logic        io_rd,
  input  logic [15:0] io_addr,
  output logic        io_oe,
  output logic [7:0]  io_data,
  output logic        fn_sel
);
  logic                    act, chk_en, chk_sel;
  logic [NUM_IO-1:0][15:0] io_base;

  ldev_regfile #(.NUM_IO(NUM_IO), .NUM_IRQ(NUM_IRQ), .NUM_DMA(NUM_DMA)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_rst(cfg_rst),
    .cfg_idx(cfg_idx), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .act_o(act), .chk_en_o(chk_en), .chk_sel_o(chk_sel), .io_base_o(io_base)
  );

  ldev_io_decode #(.NUM_IO(NUM_IO), .IO_SPAN(IO_SPAN)) u_dec (
    .clk(clk), .rst_n(rst_n), .io_rd(io_rd), .io_addr(io_addr), .io_base(io_base),
    .act(act), .chk_en(chk_en), .chk_sel(chk_sel),
    .io_oe(io_oe), .io_data(io_data), .fn_sel(fn_sel)
  );
endmodule

// File: tb/sim_ldev_cfg_top.sv
module sim_ldev_cfg_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_rst = 1'b0;
  logic [7:0]  cfg_idx = 8'h00;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [7:0]  cfg_rdata;
  logic        io_rd = 1'b0;
  logic [15:0] io_addr = 16'h0000;
  logic        io_oe;
  logic [7:0]  io_data;
  logic        fn_sel;

  always #5 clk = ~clk;

  ldev_cfg_top u0 (
    .clk(clk), .rst_n(rst_n), .cfg_rst(cfg_rst), .cfg_idx(cfg_idx), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .io_rd(io_rd), .io_addr(io_addr),
    .io_oe(io_oe), .io_data(io_data), .fn_sel(fn_sel)
  );

  typedef struct {
    bit         is_io;
    logic [7:0] data;
    logic       oe;
    logic       sel;
    string      tag;
  } exp_t;

  exp_t q[$];
  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  // Monitor: compare one expected item per cycle, at the falling edge
  always @(negedge clk) begin
    exp_t e;
    if (q.size() > 0) begin
      e = q.pop_front();
      vectors++;
      if (!e.is_io) begin
        if (cfg_rdata !== e.data) begin
          miscompares++;
          $display("FAIL %s: cfg_rdata actual %02h expected %02h", e.tag, cfg_rdata, e.data);
        end
      end else if (io_oe !== e.oe || fn_sel !== e.sel || io_data !== e.data) begin
        miscompares++;
        $display("FAIL %s: oe/sel/data actual %0b/%0b/%02h expected %0b/%0b/%02h",
                 e.tag, io_oe, fn_sel, io_data, e.oe, e.sel, e.data);
      end
    end
  end

  task automatic wr(input logic [7:0] idx, input logic [7:0] val);
    @(posedge clk); #2;
    io_rd = 1'b0; cfg_idx = idx; cfg_wdata = val; cfg_wr = 1'b1;
    @(posedge clk); #2;
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] idx, input logic [7:0] exp, input string tag);
    exp_t e;
    @(posedge clk); #2;
    io_rd = 1'b0; cfg_idx = idx;
    e.is_io = 1'b0; e.data = exp; e.oe = 1'b0; e.sel = 1'b0; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic bus(input logic rd_en, input logic [15:0] a, input logic exp_oe,
                     input logic exp_sel, input logic [7:0] exp_d, input string tag);
    exp_t e;
    @(posedge clk); #2;
    io_rd = rd_en; io_addr = a;
    e.is_io = 1'b1; e.data = exp_d; e.oe = exp_oe; e.sel = exp_sel; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // Power-up values
    rd(8'h30, 8'h00, "R7 act reset");
    rd(8'h31, 8'h00, "R7 chk reset");
    rd(8'h74, 8'h04, "R7 dma0 reset");
    rd(8'h75, 8'h04, "R7 dma1 reset");
    rd(8'h61, 8'h00, "R7 base reset");
    // Base registers
    wr(8'h60, 8'h12); wr(8'h61, 8'h40);
    wr(8'h6E, 8'h03); wr(8'h6F, 8'hF8);
    wr(8'h62, 8'hFF);
    rd(8'h60, 8'h12, "R4 base0 hi");
    rd(8'h61, 8'h40, "R4 base0 lo");
    rd(8'h6F, 8'hF8, "R4 base7 lo");
    rd(8'h62, 8'hFF, "R4 base1 hi all bits");
    // Interrupt and DMA entries
    wr(8'h70, 8'hFB); wr(8'h73, 8'hFF); wr(8'h74, 8'hFD);
    rd(8'h70, 8'h0B, "R5 irq0 level");
    rd(8'h73, 8'h03, "R5 irq1 type");
    rd(8'h74, 8'h05, "R6 dma0 channel");
    // Inactive, range check off: silent
    bus(1'b1, 16'h1240, 1'b0, 1'b0, 8'h00, "R11 inactive no check");
    // Range check with select set
    wr(8'h31, 8'hFF);
    rd(8'h31, 8'h03, "R2 chk reserved bits");
    bus(1'b1, 16'h1244, 1'b1, 1'b0, 8'h55, "R10 pattern 55");
    wr(8'h31, 8'h02);
    bus(1'b1, 16'h1240, 1'b1, 1'b0, 8'hAA, "R10 pattern AA at base");
    bus(1'b1, 16'h1247, 1'b1, 1'b0, 8'hAA, "R8 last byte hit");
    bus(1'b1, 16'h1248, 1'b0, 1'b0, 8'h00, "R8 past end miss");
    bus(1'b1, 16'h123F, 1'b0, 1'b0, 8'h00, "R8 below base miss");
    bus(1'b1, 16'h03FF, 1'b1, 1'b0, 8'hAA, "R8 range7 hit");
    bus(1'b0, 16'h1240, 1'b0, 1'b0, 8'h00, "R8 no read strobe");
    bus(1'b1, 16'h0003, 1'b0, 1'b0, 8'h00, "R8 zero base disabled");
    // Wrap check on range2 at 0xFFFC
    wr(8'h64, 8'hFF); wr(8'h65, 8'hFC);
    bus(1'b1, 16'hFFFF, 1'b1, 1'b0, 8'hAA, "R8 top of space hit");
    bus(1'b1, 16'h0002, 1'b0, 1'b0, 8'h00, "R8 no wrap");
    // Activation blocked while checking
    wr(8'h30, 8'h01);
    rd(8'h30, 8'h00, "R3 activate blocked");
    // Activate with check off
    wr(8'h31, 8'h00);
    wr(8'h30, 8'hFF);
    rd(8'h30, 8'h01, "R1 act reserved bits");
    bus(1'b1, 16'h1243, 1'b1, 1'b1, 8'h00, "R9 active hit");
    bus(1'b1, 16'h1250, 1'b0, 1'b0, 8'h00, "R8 active miss");
    // Check enabled while active
    wr(8'h31, 8'h03);
    rd(8'h30, 8'h01, "R3 stays active");
    bus(1'b1, 16'h1243, 1'b1, 1'b1, 8'h00, "R11 no pattern while active");
    // Deactivate: pattern comes back
    wr(8'h30, 8'h00);
    bus(1'b1, 16'h1243, 1'b1, 1'b0, 8'h55, "R10 pattern after deactivate");
    // Soft reset pulse
    @(posedge clk); #2 cfg_rst = 1'b1;
    @(posedge clk); #2 cfg_rst = 1'b0;
    rd(8'h31, 8'h00, "R7 chk after pulse");
    rd(8'h74, 8'h04, "R7 dma0 after pulse");
    rd(8'h70, 8'h00, "R7 irq after pulse");
    rd(8'h60, 8'h00, "R7 base after pulse");
    bus(1'b1, 16'h1243, 1'b0, 1'b0, 8'h00, "R7 decode after pulse");
    @(posedge clk); #2 io_rd = 1'b0;
    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule